// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Evaluator

This block applies a gamma transfer curve to 12-bit colour components as they stream through a display pipeline. The curve is built from 64 straight-line segments. Each segment has one coefficient word that holds a slope and an intercept. The segments are narrow near black and grow wider toward white, so the dark end of the curve, where gamma bends most, is modelled finely. The block finds the segment for a pixel with a leading-one decode of the code rather than a uniform index.

Software loads the 64 coefficient words through a simple register-style write port into a staging bank. The curve in use changes only when the frame-boundary strobe arrives, so a frame is never shaded with a half-loaded curve. Red, green and blue share the one curve: the components are fed one per cycle over the valid/ready pixel path. The path has two pipeline stages. The first locates the segment and reads its coefficients. The second multiplies, adds and saturates.

Top module: `gamma_pwl_curve`

## Requirements
- R1: Segment index order is ascending in input code. Segments 0 to 15 each cover one code (segment i starts at i). Segments 16 to 35 form five groups of four, whose widths are 4, 8, 16, 32 and 64 and whose first segments start at 16, 32, 64, 128 and 256. Segments 36 to 63 are each 128 codes wide, starting at 512 and ending at 4095.
- R2: A coefficient write stores `cfg_wdata` into the segment numbered `cfg_addr`. Bits 27:16 hold the unsigned 12-bit slope, scaled by 256. Bits 11:0 hold the 12-bit intercept, which is the curve value at the segment's first code. All other bits are ignored.
- R3: For an input code x in a segment with start s, the output is intercept + (((x − s) × slope) >> 8).
- R4: A result above 4095 is saturated to 4095.
- R5: Coefficient writes go to a staging bank and reach the active curve only on a cycle with `frame_sync` high. A write made in the same cycle as the strobe is included. A pixel accepted in the strobe cycle, or earlier, is evaluated with the previous curve.
- R6: A pixel accepted on a rising edge appears on `out_valid`/`out_pix` after the next rising edge, provided `in_ready` is high there. A cycle with no accepted pixel produces no output.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` hold their values.
- R8: `in_ready` is high exactly when the output register is empty or being drained: it is low while `out_valid` is high and `out_ready` is low.
- R9: After reset the output is empty. Every segment holds the identity coefficients (slope 256, intercept equal to the segment start), so out_pix equals the input pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 6 | Segment number to write |
| cfg_wdata | input | 32 | Coefficient word: slope 27:16, intercept 11:0 |
| frame_sync | input | 1 | Frame-boundary strobe that commits staged coefficients |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_pix | input | 12 | Input component code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_pix | output | 12 | Gamma-corrected component |

## Verification
A wrong segment decode or a stale coefficient in the active bank shows up at `out_pix` two edges after the pixel is accepted. The error appears only for codes inside the affected segment, so the stimulus probes both edges of every segment width class. A staging bank that leaks into the active curve early shows as a changed result for a pixel sent before the strobe. A pipeline valid or stall bug shows the next cycle as a dropped, duplicated or drifting output word under back-pressure.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
  parameter int PIX_W        = 12;
  parameter int SEG_CNT      = 64;
  parameter int SEG_AW       = $clog2(SEG_CNT);
  parameter int FINE_SEGS    = 16;
  parameter int GROUP_SEGS   = 4;
  parameter int GROUP_CNT    = 5;
  parameter int COARSE_LOG2  = 7;
  parameter int SLOPE_FRAC   = 8;
  parameter int WORD_W       = 32;
  parameter int SLOPE_LSB    = 16;

  localparam int FINE_LOG2    = $clog2(FINE_SEGS);
  localparam int GROUP_LOG2   = $clog2(GROUP_SEGS);
  localparam int FIRST_COARSE = FINE_SEGS + GROUP_SEGS * GROUP_CNT;
  localparam int COARSE_BASE  = 1 << (COARSE_LOG2 + GROUP_LOG2);
  localparam int OFF_W        = COARSE_LOG2;
  localparam int PROD_W       = OFF_W + PIX_W;

  typedef struct packed {
    logic [PIX_W-1:0] slope;
    logic [PIX_W-1:0] icpt;
  } coef_t;

  // first input code covered by a segment
  function automatic logic [PIX_W-1:0] seg_start(input int idx);
    int grp;
    int base;
    if (idx < FINE_SEGS) begin
      base = idx;
    end else if (idx < FIRST_COARSE) begin
      grp  = (idx - FINE_SEGS) / GROUP_SEGS;
      base = (FINE_SEGS << grp) +
             ((idx - FINE_SEGS) % GROUP_SEGS) * ((FINE_SEGS / GROUP_SEGS) << grp);
    end else begin
      base = COARSE_BASE + (idx - FIRST_COARSE) * (1 << COARSE_LOG2);
    end
    return PIX_W'(base);
  endfunction
endpackage

// File: rtl/gamma_seg_locate.sv
module gamma_seg_locate
  import gamma_pwl_pkg::*;
(
  input  logic [PIX_W-1:0]  pix,
  output logic [SEG_AW-1:0] seg,
  output logic [OFF_W-1:0]  off
);
  int msb;
  int shamt;
  int idx;
  int rem;

  always_comb begin
    msb = 0;
    for (int b = 0; b < PIX_W; b++) begin
      if (pix[b]) msb = b;
    end
    shamt = 0;
    idx   = 0;
    rem   = 0;
    if (int'(pix) < FINE_SEGS) begin
      idx = int'(pix);
      rem = 0;
    end else if (msb < FINE_LOG2 + GROUP_CNT) begin
      shamt = msb - GROUP_LOG2;
      idx   = FINE_SEGS + GROUP_SEGS * (msb - FINE_LOG2) +
              ((int'(pix) >> shamt) & (GROUP_SEGS - 1));
      rem   = int'(pix) & ((1 << shamt) - 1);
    end else begin
      idx = FIRST_COARSE + ((int'(pix) - COARSE_BASE) >> COARSE_LOG2);
      rem = int'(pix) & ((1 << COARSE_LOG2) - 1);
    end
    seg = SEG_AW'(idx);
    off = OFF_W'(rem);
  end
endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
  import gamma_pwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_AW-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              commit,
  input  logic [SEG_AW-1:0] rd_addr,
  output coef_t             rd_coef
);
  coef_t stage_q  [SEG_CNT];
  coef_t stage_d  [SEG_CNT];
  coef_t active_q [SEG_CNT];
  coef_t active_d [SEG_CNT];
  coef_t wr_coef;

  assign wr_coef.slope = wr_word[SLOPE_LSB +: PIX_W];
  assign wr_coef.icpt  = wr_word[PIX_W-1:0];

  always_comb begin
    for (int i = 0; i < SEG_CNT; i++) begin
      stage_d[i] = stage_q[i];
      if (wr_en && (wr_addr == SEG_AW'(i))) stage_d[i] = wr_coef;
      active_d[i] = commit ? stage_d[i] : active_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_CNT; i++) begin
        stage_q[i].slope  <= PIX_W'(1 << SLOPE_FRAC);
        stage_q[i].icpt   <= seg_start(i);
        active_q[i].slope <= PIX_W'(1 << SLOPE_FRAC);
        active_q[i].icpt  <= seg_start(i);
      end
    end else begin
      for (int i = 0; i < SEG_CNT; i++) begin
        stage_q[i]  <= stage_d[i];
        active_q[i] <= active_d[i];
      end
    end
  end

  assign rd_coef = active_q[rd_addr];
endmodule

// File: rtl/gamma_pwl_curve.sv
module gamma_pwl_curve
  import gamma_pwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frame_sync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix
);
  localparam logic [PIX_W:0] SAT_MAX = {1'b0, {PIX_W{1'b1}}};

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // stage 1: locate segment, fetch coefficients
  logic [SEG_AW-1:0] loc_seg;
  logic [OFF_W-1:0]  loc_off;
  coef_t             loc_coef;
  logic              adv;

  gamma_seg_locate u_locate (
    .pix (in_pix),
    .seg (loc_seg),
    .off (loc_off)
  );

  gamma_coef_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_word (cfg_wdata),
    .commit  (frame_sync),
    .rd_addr (loc_seg),
    .rd_coef (loc_coef)
  );

  logic             s1_valid_q, s1_valid_d;
  logic [OFF_W-1:0] s1_off_q;
  coef_t            s1_coef_q;
  logic             o_valid_q, o_valid_d;
  logic [PIX_W-1:0] o_pix_q, o_pix_d;

  assign adv      = rst_sync_n && (!o_valid_q || out_ready);
  assign in_ready = adv;

  // stage 2: interpolate and saturate
  logic [PROD_W-1:0] prod;
  logic [PIX_W:0]    sum;

  always_comb begin
    prod      = PROD_W'(s1_off_q) * PROD_W'(s1_coef_q.slope);
    sum       = {1'b0, s1_coef_q.icpt} + (PIX_W+1)'(prod >> SLOPE_FRAC);
    o_pix_d   = (sum > SAT_MAX) ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
    s1_valid_d = in_valid;
    o_valid_d  = s1_valid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      o_valid_q  <= 1'b0;
    end else if (adv) begin
      s1_valid_q <= s1_valid_d;
      o_valid_q  <= o_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_off_q  <= loc_off;
      s1_coef_q <= loc_coef;
      o_pix_q   <= o_pix_d;
    end
  end

  assign out_valid = o_valid_q;
  assign out_pix   = o_pix_q;
endmodule

// File: rtl/gamma_pwl_curve_chk.sv
module gamma_pwl_curve_chk
  import gamma_pwl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix
);
  a_r6_accept_emerges: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  a_r6_bubble_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) ##1 in_ready |=> !out_valid);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r8_block_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind gamma_pwl_curve gamma_pwl_curve_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix)
);

// File: tb/gamma_pwl_curve_tb.sv
module gamma_pwl_curve_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        frame_sync;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_pix;
  logic        out_valid;
  logic        out_ready;
  logic [11:0] out_pix;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  gamma_pwl_curve u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_sync(frame_sync), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  // bench model of the curve, built from the requirements
  int m_act_slope [64];
  int m_act_icpt  [64];
  int m_stg_slope [64];
  int m_stg_icpt  [64];

  function automatic int m_base(input int i);
    if (i < 16) return i;
    if (i < 20) return 16 + (i - 16) * 4;
    if (i < 24) return 32 + (i - 20) * 8;
    if (i < 28) return 64 + (i - 24) * 16;
    if (i < 32) return 128 + (i - 28) * 32;
    if (i < 36) return 256 + (i - 32) * 64;
    return 512 + (i - 36) * 128;
  endfunction

  function automatic int m_eval(input int x);
    int s = 0;
    int v;
    for (int i = 0; i < 64; i++) if (m_base(i) <= x) s = i;
    v = m_act_icpt[s] + (((x - m_base(s)) * m_act_slope[s]) >> 8);
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 64; i++) begin
      m_act_slope[i] = 256; m_act_icpt[i] = m_base(i);
      m_stg_slope[i] = 256; m_stg_icpt[i] = m_base(i);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frame_sync = 0;
    in_valid = 0; in_pix = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_reset();
  endtask

  task automatic cfg_write(input int seg, input logic [31:0] word, input bit strobe);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(seg); cfg_wdata = word; frame_sync = strobe;
    @(negedge clk);
    cfg_we = 0; frame_sync = 0;
    m_stg_slope[seg] = int'(word[27:16]);
    m_stg_icpt[seg]  = int'(word[11:0]);
    if (strobe) m_commit();
  endtask

  function automatic void m_commit();
    for (int i = 0; i < 64; i++) begin
      m_act_slope[i] = m_stg_slope[i]; m_act_icpt[i] = m_stg_icpt[i];
    end
  endfunction

  // drive one pixel with an empty pipeline, return the result
  task automatic send_one(input int x, input bit strobe, output int res, output bit vld);
    @(negedge clk);
    in_valid = 1; in_pix = 12'(x); out_ready = 1; frame_sync = strobe;
    @(negedge clk);
    in_valid = 0; frame_sync = 0;
    @(negedge clk);
    vld = out_valid; res = int'(out_pix);
  endtask

  localparam logic [23:0] VECS [16] = '{
    {12'd0, 12'd0},       {12'd15, 12'd15},     {12'd16, 12'd16},
    {12'd19, 12'd19},     {12'd31, 12'd31},     {12'd32, 12'd32},
    {12'd100, 12'd100},   {12'd255, 12'd255},   {12'd256, 12'd256},
    {12'd511, 12'd511},   {12'd512, 12'd512},   {12'd1000, 12'd1000},
    {12'd2047, 12'd2047}, {12'd3968, 12'd3968}, {12'd4000, 12'd4000},
    {12'd4095, 12'd4095}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    bit v;
    do_reset();
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R8 in_ready when empty", int'(in_ready), 1);

    // R9/R1/R3 identity curve over every segment width class
    foreach (VECS[k]) begin
      send_one(int'(VECS[k][23:12]), 0, r, v);
      check("R6 result valid", int'(v), 1);
      check("R9 identity", r, int'(VECS[k][11:0]));
    end

    // R2 field placement, ignored bits set; R5 staged only
    cfg_write(40, 32'hF080_F064, 0);
    send_one(1124, 0, r, v);
    check("R5 staged write not yet active", r, 1124);
    // R5 pixel in strobe cycle uses old curve, later pixel the new one
    send_one(1124, 1, r, v);
    check("R5 strobe-cycle pixel old curve", r, 1124);
    m_commit();
    send_one(1124, 0, r, v);
    check("R2 R3 seg40 interior", r, m_eval(1124));
    check("R3 seg40 value", r, 150);
    send_one(1024, 0, r, v);
    check("R3 seg40 start is intercept", r, 100);
    send_one(1023, 0, r, v);
    check("R1 seg39 end untouched", r, 1023);

    // R1 boundary between segments 16 and 17; R5 write with strobe same cycle
    cfg_write(17, {4'h0, 12'd512, 4'h0, 12'd7}, 1);
    send_one(19, 0, r, v);
    check("R1 code19 in seg16", r, 19);
    send_one(20, 0, r, v);
    check("R5 R1 code20 seg17 start", r, 7);
    send_one(23, 0, r, v);
    check("R3 seg17 end", r, m_eval(23));

    // R4 saturation in the last segment
    cfg_write(63, {4'h0, 12'd4095, 4'h0, 12'd4000}, 1);
    send_one(4095, 0, r, v);
    check("R4 saturate", r, 4095);
    send_one(3968, 0, r, v);
    check("R4 start no saturation", r, 4000);

    // R7/R8 back-pressure
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_pix = 12'd1124;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check("R6 valid under stall", int'(out_valid), 1);
    check("R8 in_ready low on stall", int'(in_ready), 0);
    r = int'(out_pix);
    repeat (3) @(negedge clk);
    check("R7 held value", int'(out_pix), r);
    check("R7 held valid", int'(out_valid), 1);
    check("R3 stalled result", r, m_eval(1124));
    out_ready = 1;
    @(negedge clk);
    check("R6 drained no bubble output", int'(out_valid), 0);

    // R9 reset restores identity
    do_reset();
    send_one(1124, 0, r, v);
    check("R9 identity after reset", r, 1124);
    send_one(4095, 0, r, v);
    check("R9 identity top code", r, 4095);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule